// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit fixed-point signal processor. It holds four 16-bit operand registers and two 40-bit accumulators. On each enabled cycle it multiplies two 16-bit operands into a full 32-bit product. It then loads that product into one accumulator, adds it to that accumulator, or subtracts it from that accumulator. Either operand may be one of the four registers or the high word (bits 31..16) of either accumulator. This lets a result feed straight back into the next multiply.

The product is widened to 40 bits before the accumulate step, which leaves 8 guard bits for growth. It is sign-extended when at least one operand is treated as signed and zero-extended when both operands are unsigned. Arithmetic is in integer form with no alignment shift. Overflow past 40 bits wraps without any indication. Shifting, rounding, saturation, decode and memory access belong to the surrounding datapath.

Top module: `mac16_core`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears all four operand registers and both accumulators to zero.
- R2: When wr_en is high at an edge, wr_data is stored in the operand register chosen by wr_sel (0 = X0, 1 = X1, 2 = Y0, 3 = Y1). A multiply issued at that same edge still uses the old register value.
- R3: The operand selects src1_sel and src2_sel encode the source as follows: 0 = X0, 1 = X1, 2 = Y0, 3 = Y1, 4 = accumulator A bits 31..16, 5 = accumulator B bits 31..16, 6 and 7 = constant zero. Accumulator values are the ones held before the edge.
- R4: sign_mode 2'b00 multiplies both operands as two's complement. The 32-bit product is sign-extended into bits 39..32.
- R5: sign_mode 2'b01 treats src1 as signed and src2 as unsigned. The product is sign-extended into bits 39..32.
- R6: sign_mode 2'b10 or 2'b11 treats both operands as unsigned. The product is zero-extended, so bits 39..32 of a loaded result are zero.
- R7: The op field selects the accumulator update: 0 = load product, 1 = add product, 2 = subtract product, 3 = leave both accumulators unchanged.
- R8: dst_sel 0 writes accumulator A and dst_sel 1 writes accumulator B. The other accumulator keeps its value.
- R9: A multiply issued at a clock edge shows its result on acc_a/acc_b right after that edge, one cycle per operation.
- R10: Accumulation wraps modulo 2^40 and raises no flag.
- R11: With mac_en low, both accumulators hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Operand register write enable |
| wr_sel | input | 2 | Operand register to write (X0, X1, Y0, Y1) |
| wr_data | input | 16 | Value to write |
| mac_en | input | 1 | Perform a multiply-accumulate this cycle |
| src1_sel | input | 3 | First operand source |
| src2_sel | input | 3 | Second operand source |
| sign_mode | input | 2 | Operand signedness mode |
| op | input | 2 | Accumulator update operation |
| dst_sel | input | 1 | Destination accumulator (0 = A, 1 = B) |
| acc_a | output | 40 | Accumulator A |
| acc_b | output | 40 | Accumulator B |

## Verification
The accumulators are the only state visible at the ports, so a fault in an accumulator shows on acc_a or acc_b right after the edge that caused it. A corrupted operand register stays hidden until a multiply reads it. That multiply exposes the fault in the destination accumulator one cycle later. A wrong guard-bit extension or a wrong signedness decode shows first in bits 39..32 of a loaded result. Faults in the accumulator-feedback path show only when an accumulator high word is selected as an operand.

// File: rtl/mac16_pkg.sv
package mac16_pkg;
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2,
        OP_HOLD = 2'd3
    } mac_op_e;

    typedef enum logic [2:0] {
        SRC_X0   = 3'd0,
        SRC_X1   = 3'd1,
        SRC_Y0   = 3'd2,
        SRC_Y1   = 3'd3,
        SRC_AHI  = 3'd4,
        SRC_BHI  = 3'd5,
        SRC_ZERO = 3'd6
    } src_sel_e;

    localparam logic [1:0] MODE_SS = 2'b00;
    localparam logic [1:0] MODE_SU = 2'b01;
    localparam int         NUM_OPREGS = 4;
    localparam int         NUM_SRCS   = 2;
endpackage

// File: rtl/mac16_opsel.sv
module mac16_opsel #(
    parameter int DW = 16
) (
    input  logic [3:0][DW-1:0] regs,
    input  logic [DW-1:0]      hi_a,
    input  logic [DW-1:0]      hi_b,
    input  logic [2:0]         sel,
    output logic [DW-1:0]      operand
);
    always_comb begin
        case (sel)
            3'd0:    operand = regs[0];
            3'd1:    operand = regs[1];
            3'd2:    operand = regs[2];
            3'd3:    operand = regs[3];
            3'd4:    operand = hi_a;
            3'd5:    operand = hi_b;
            default: operand = '0;
        endcase
    end
endmodule

// File: rtl/mac16_mul.sv
module mac16_mul #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW-1:0]   b,
    input  logic            a_signed,
    input  logic            b_signed,
    output logic [2*DW-1:0] product
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] ext_a;
    logic [PW-1:0] ext_b;

    // Operands widened to product width; the low PW bits of the product
    // are exact for every signedness combination.
    always_comb begin
        ext_a   = a_signed ? {{DW{a[DW-1]}}, a} : {{DW{1'b0}}, a};
        ext_b   = b_signed ? {{DW{b[DW-1]}}, b} : {{DW{1'b0}}, b};
        product = ext_a * ext_b;
    end
endmodule

// File: rtl/mac16_core.sv
module mac16_core #(
    parameter int DW    = 16,
    parameter int GUARD = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic [1:0]              wr_sel,
    input  logic [DW-1:0]           wr_data,
    input  logic                    mac_en,
    input  logic [2:0]              src1_sel,
    input  logic [2:0]              src2_sel,
    input  logic [1:0]              sign_mode,
    input  logic [1:0]              op,
    input  logic                    dst_sel,
    output logic [2*DW+GUARD-1:0]   acc_a,
    output logic [2*DW+GUARD-1:0]   acc_b
);
    import mac16_pkg::*;

    localparam int PW = 2 * DW;
    localparam int AW = PW + GUARD;

    typedef struct packed {
        logic [3:0][DW-1:0] regs;
        logic [AW-1:0]      acc_a;
        logic [AW-1:0]      acc_b;
    } mac_state_t;

    mac_state_t s_d, s_q;

    logic [NUM_SRCS-1:0][DW-1:0] opnd;
    logic [NUM_SRCS-1:0][2:0]    src_sel;
    logic                        a_signed, b_signed;
    logic [PW-1:0]               product;

    assign src_sel[0] = src1_sel;
    assign src_sel[1] = src2_sel;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_SRCS; gi++) begin : g_opsel
            mac16_opsel #(.DW(DW)) u_opsel (
                .regs    (s_q.regs),
                .hi_a    (s_q.acc_a[PW-1:DW]),
                .hi_b    (s_q.acc_b[PW-1:DW]),
                .sel     (src_sel[gi]),
                .operand (opnd[gi])
            );
        end
    endgenerate

    always_comb begin
        a_signed = (sign_mode == MODE_SS) || (sign_mode == MODE_SU);
        b_signed = (sign_mode == MODE_SS);
    end

    mac16_mul #(.DW(DW)) u_mul (
        .a        (opnd[0]),
        .b        (opnd[1]),
        .a_signed (a_signed),
        .b_signed (b_signed),
        .product  (product)
    );

    logic [AW-1:0] prod_ext_d;
    logic [AW-1:0] acc_cur;
    logic [AW-1:0] acc_new_d;

    always_comb begin
        s_d = s_q;

        if (wr_en) begin
            s_d.regs[wr_sel] = wr_data;
        end

        prod_ext_d = a_signed ? {{GUARD{product[PW-1]}}, product}
                              : {{GUARD{1'b0}}, product};
        acc_cur    = dst_sel ? s_q.acc_b : s_q.acc_a;

        case (mac_op_e'(op))
            OP_LOAD: acc_new_d = prod_ext_d;
            OP_ADD:  acc_new_d = acc_cur + prod_ext_d;
            OP_SUB:  acc_new_d = acc_cur - prod_ext_d;
            default: acc_new_d = acc_cur;
        endcase

        if (mac_en) begin
            if (dst_sel) s_d.acc_b = acc_new_d;
            else         s_d.acc_a = acc_new_d;
        end

        if (rst) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign acc_a = s_q.acc_a;
    assign acc_b = s_q.acc_b;
endmodule

// File: rtl/mac16_core_chk.sv
module mac16_core_chk #(
    parameter int AW = 40
) (
    input logic          clk,
    input logic          rst,
    input logic          mac_en,
    input logic [1:0]    op,
    input logic [1:0]    sign_mode,
    input logic          dst_sel,
    input logic [AW-1:0] acc_a,
    input logic [AW-1:0] acc_b
);
    logic rst_seen_q = 1'b0;
    logic rst_prev_q = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst) rst_seen_q <= 1'b1;
        if (rst_seen_q && rst_prev_q) begin
            assert_reset_clears_R1: assert (acc_a == '0 && acc_b == '0)
                else $error("accumulators not cleared after reset");
        end
    end

    // R11: idle cycle leaves both accumulators alone
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !mac_en |=> ($stable(acc_a) && $stable(acc_b)));

    // R7: hold opcode leaves both accumulators alone
    assert_hold_op_R7: assert property (@(posedge clk) disable iff (rst)
        (mac_en && op == 2'd3) |=> ($stable(acc_a) && $stable(acc_b)));

    // R8: only the selected accumulator may change
    assert_dst_a_only_R8: assert property (@(posedge clk) disable iff (rst)
        (mac_en && !dst_sel) |=> $stable(acc_b));
    assert_dst_b_only_R8: assert property (@(posedge clk) disable iff (rst)
        (mac_en && dst_sel) |=> $stable(acc_a));

    // R6: unsigned load leaves the guard bits clear
    assert_unsigned_guard_R6: assert property (@(posedge clk) disable iff (rst)
        (mac_en && op == 2'd0 && sign_mode[1] && !dst_sel)
            |=> (acc_a[AW-1:AW-8] == 8'h00));

    // R4 / R5: signed load fills guard bits with the product sign
    assert_signed_guard_R4_R5: assert property (@(posedge clk) disable iff (rst)
        (mac_en && op == 2'd0 && !sign_mode[1] && dst_sel)
            |=> (acc_b[AW-1:AW-8] == {8{acc_b[AW-9]}}));
endmodule

bind mac16_core mac16_core_chk #(.AW(AW)) u_chk (.*);

// File: tb/mac16_core_bench.sv
module mac16_core_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [1:0]  wr_sel;
    logic [15:0] wr_data;
    logic        mac_en;
    logic [2:0]  src1_sel, src2_sel;
    logic [1:0]  sign_mode, op;
    logic        dst_sel;
    logic [39:0] acc_a, acc_b;

    int checks = 0;
    int errors = 0;

    logic [15:0] m_reg [4];
    logic [39:0] m_a, m_b;

    always #10 clk = ~clk;

    mac16_core u_mac16_core (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .mac_en(mac_en), .src1_sel(src1_sel), .src2_sel(src2_sel),
        .sign_mode(sign_mode), .op(op), .dst_sel(dst_sel),
        .acc_a(acc_a), .acc_b(acc_b)
    );

    task automatic chk(string tag, logic [39:0] got, logic [39:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [15:0] pick(logic [2:0] s);
        case (s)
            3'd0, 3'd1, 3'd2, 3'd3: return m_reg[s[1:0]];
            3'd4: return m_a[31:16];
            3'd5: return m_b[31:16];
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [39:0] mul40(logic [15:0] x, logic [15:0] y, logic [1:0] md);
        longint vx, vy, p;
        vx = (md != 2'b10 && md != 2'b11) ? longint'($signed(x)) : longint'(x);
        vy = (md == 2'b00) ? longint'($signed(y)) : longint'(y);
        p  = vx * vy;
        return p[39:0];
    endfunction

    task automatic idle_inputs();
        wr_en = 0; wr_sel = 0; wr_data = 0; mac_en = 0;
        src1_sel = 0; src2_sel = 0; sign_mode = 0; op = 0; dst_sel = 0;
    endtask

    task automatic wr(logic [1:0] sel, logic [15:0] v);
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_sel = sel; wr_data = v;
        m_reg[sel] = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    // one multiply; model updated from the requirement text, then both accs compared
    task automatic mac(string tag, logic [2:0] s1, logic [2:0] s2, logic [1:0] md,
                       logic [1:0] opc, logic dst);
        logic [39:0] p, cur, nxt;
        p   = mul40(pick(s1), pick(s2), md);
        cur = dst ? m_b : m_a;
        case (opc)
            2'd0: nxt = p;
            2'd1: nxt = cur + p;
            2'd2: nxt = cur - p;
            default: nxt = cur;
        endcase
        @(negedge clk);
        idle_inputs();
        mac_en = 1; src1_sel = s1; src2_sel = s2; sign_mode = md; op = opc; dst_sel = dst;
        @(negedge clk);
        mac_en = 0;
        if (dst) m_b = nxt; else m_a = nxt;
        chk({tag, " accA"}, acc_a, m_a);
        chk({tag, " accB"}, acc_b, m_b);
    endtask

    task automatic t_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 4; i++) m_reg[i] = 16'h0;
        m_a = 0; m_b = 0;
        chk("R1 reset accA", acc_a, 40'h0);
        chk("R1 reset accB", acc_b, 40'h0);
    endtask

    task automatic t_regs_cleared();
        mac("R1 regs zero X0*Y1", 3'd0, 3'd3, 2'b00, 2'd0, 1'b0);
    endtask

    task automatic t_signed();
        wr(2'd0, 16'd3);
        wr(2'd1, 16'd5);
        mac("R2 R4 R9 X0*X1", 3'd0, 3'd1, 2'b00, 2'd0, 1'b0);
        chk("R4 literal 15", acc_a, 40'd15);
        wr(2'd0, 16'hFFFE);
        wr(2'd2, 16'd7);
        mac("R4 R8 -2*7 to B", 3'd0, 3'd2, 2'b00, 2'd0, 1'b1);
        chk("R4 literal -14", acc_b, 40'hFF_FFFF_FFF2);
        chk("R8 A untouched", acc_a, 40'd15);
    endtask

    task automatic t_mixed();
        wr(2'd0, 16'hFFFF);
        wr(2'd3, 16'hFFFF);
        mac("R5 signed*unsigned", 3'd0, 3'd3, 2'b01, 2'd0, 1'b1);
        chk("R5 literal -65535", acc_b, 40'hFF_FFFF_0001);
    endtask

    task automatic t_unsigned();
        mac("R6 unsigned*unsigned", 3'd0, 3'd3, 2'b10, 2'd0, 1'b0);
        chk("R6 literal", acc_a, 40'h00_FFFE_0001);
        mac("R6 mode 11", 3'd0, 3'd3, 2'b11, 2'd0, 1'b0);
        mac("R4 ss same data", 3'd0, 3'd3, 2'b00, 2'd0, 1'b0);
        chk("R4 literal 1", acc_a, 40'd1);
    endtask

    task automatic t_add_sub();
        wr(2'd1, 16'd100);
        wr(2'd2, 16'hFFF6);
        mac("R7 load 100*-10", 3'd1, 3'd2, 2'b00, 2'd0, 1'b1);
        mac("R7 add", 3'd1, 3'd1, 2'b00, 2'd1, 1'b1);
        chk("R7 literal add", acc_b, 40'd9000);
        mac("R7 sub", 3'd1, 3'd2, 2'b00, 2'd2, 1'b1);
        chk("R7 literal sub", acc_b, 40'd10000);
    endtask

    task automatic t_hold();
        mac("R7 hold op", 3'd1, 3'd1, 2'b00, 2'd3, 1'b0);
        @(negedge clk);
        idle_inputs();
        src1_sel = 3'd1; src2_sel = 3'd1; op = 2'd0;
        @(negedge clk);
        chk("R11 idle accA", acc_a, m_a);
        chk("R11 idle accB", acc_b, m_b);
    endtask

    task automatic t_acc_operand();
        wr(2'd0, 16'h0100);
        mac("R3 build A", 3'd0, 3'd0, 2'b00, 2'd0, 1'b0);
        chk("R3 A=0x10000", acc_a, 40'h00_0001_0000);
        wr(2'd2, 16'd7);
        mac("R3 Ahi*Y0", 3'd4, 3'd2, 2'b00, 2'd0, 1'b1);
        chk("R3 literal 7", acc_b, 40'd7);
        mac("R3 Bhi*X0 (Bhi=0)", 3'd5, 3'd0, 2'b00, 2'd0, 1'b0);
        chk("R3 literal 0", acc_a, 40'd0);
        mac("R3 sel 6", 3'd6, 3'd2, 2'b00, 2'd0, 1'b1);
        mac("R3 sel 7", 3'd2, 3'd7, 2'b10, 2'd0, 1'b0);
        chk("R3 zero sel literal", acc_b, 40'd0);
    endtask

    task automatic t_same_cycle_write();
        wr(2'd3, 16'd9);
        wr(2'd2, 16'd2);
        @(negedge clk);
        idle_inputs();
        wr_en = 1; wr_sel = 2'd3; wr_data = 16'd50;
        mac_en = 1; src1_sel = 3'd3; src2_sel = 3'd2; sign_mode = 2'b00; op = 2'd0;
        @(negedge clk);
        idle_inputs();
        m_reg[3] = 16'd50;
        m_a = 40'd18;
        chk("R2 old value used", acc_a, 40'd18);
        mac("R2 new value", 3'd3, 3'd2, 2'b00, 2'd0, 1'b0);
        chk("R2 literal 100", acc_a, 40'd100);
    endtask

    task automatic t_wrap();
        wr(2'd0, 16'hFFFF);
        mac("R10 start", 3'd0, 3'd0, 2'b10, 2'd0, 1'b0);
        for (int i = 0; i < 300; i++) begin
            mac("R10 accumulate", 3'd0, 3'd0, 2'b10, 2'd1, 1'b0);
        end
        chk("R10 wrapped literal", acc_a, 40'(64'd301 * 64'hFFFE0001));
        mac("R10 sub below zero", 3'd6, 3'd6, 2'b00, 2'd0, 1'b1);
        wr(2'd1, 16'd1);
        mac("R10 0-1", 3'd1, 3'd1, 2'b00, 2'd2, 1'b1);
        chk("R10 literal all ones", acc_b, 40'hFF_FFFF_FFFF);
    endtask

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        m_a = 0; m_b = 0;
        for (int i = 0; i < 4; i++) m_reg[i] = 16'h0;
        t_reset();
        t_regs_cleared();
        t_signed();
        t_mixed();
        t_unsigned();
        t_add_sub();
        t_hold();
        t_acc_operand();
        t_same_cycle_write();
        t_wrap();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule